// File: doc/BRIEF.md
# Page-Oriented NAND Flash Host Sequencer with Per-Byte Chip-Enable Release

This block sits between a simple user request port and a small 8-bit NAND flash device. A request names a direction (page program or page read), a 24-bit flash address and a byte count. The sequencer then produces the whole pin-level transaction. It issues a command byte with the command latch strobe, three address bytes with the address latch strobe, and the data bytes, each clocked into the device on the rising edge of the write strobe. For a program it then sends a confirm command and waits for the device to leave its busy state. Program data arrives as a valid/ready byte stream. Read data leaves as one-cycle valid pulses.

Between individual data bytes the chip enable is driven inactive (high) to save power, on both the program and the read paths. After a read's address, the device spends time moving its array into the page buffer. The chip enable stays active for that whole period. Every read byte re-activates the chip enable together with the read strobe. The sequencer samples the bus only after the longer of two configurable access delays, one counted from the chip-enable fall and one from the read-strobe fall. If the ready/busy line stays busy too long, the request completes with an error flag.

Top module: `nand_host_seq`

## Requirements
- R1: While reset is held, chip enable, write strobe and read strobe are high, both latch strobes are low, the bus output enable is low, and `req_ack`, `rd_valid` and `wr_ready` are low.
- R2: A read request issues command byte 00h with `fl_cle` high, then exactly ADDR_CYCLES address bytes with `fl_ale` high, least significant address byte first. `fl_cle` and `fl_ale` are never high together.
- R3: A program request issues command byte 80h, the address bytes in the same order as R2, then the data bytes in stream order, then confirm byte 10h. Every byte is latched with the chip enable low and the output enable high.
- R4: A request moves exactly min(`req_len`, PAGE_BYTES) data bytes. A length of zero moves none, and a program of length zero still sends its confirm byte.
- R5: The chip enable is high for at least one cycle before every program data byte and before every read byte.
- R6: From the last read address byte until ready/busy is seen high again, the chip enable stays low.
- R7: Each read byte is sampled max(T_CEA, T_REA) cycles after the chip enable and read strobe fall together. The bytes returned equal the bytes last programmed.
- R8: The bus output enable is never high while the read strobe is low, and the write and read strobes are never low together.
- R9: After the confirm byte, and after the read address, `req_ack` rises only once ready/busy is high. `req_ack` is a single-cycle pulse, and `req_err` is low on a normal completion.
- R10: If ready/busy stays low for TIMEOUT cycles of polling, the request ends with `req_ack` and `req_err` both high. The controller accepts the next request normally.
- R11: Each write-strobe low pulse lasts exactly T_WP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Starts a request; sampled only while idle |
| req_write | input | 1 | 1 = page program, 0 = page read |
| req_addr | input | 8*ADDR_CYCLES | Flash address, sent low byte first |
| req_len | input | LEN_W | Requested byte count, capped at PAGE_BYTES |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken when high with wr_valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | One-cycle pulse per read byte |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Timeout indication, valid with req_ack |
| fl_cle | output | 1 | Command latch strobe |
| fl_ale | output | 1 | Address latch strobe |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_io_out | output | 8 | Bus value driven by the host |
| fl_io_oe | output | 1 | Host bus output enable |
| fl_io_in | input | 8 | Bus value driven by the device |
| fl_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
The bench builds the block with a 32-byte page, three address cycles, T_WP=2 and T_WH=2, T_CEA=4 against T_REA=3, and a polling limit of 200 cycles. Making the two access delays unequal means a sampler that waits for only the shorter delay reads the device model's filler byte instead of data. The short polling limit brings the timeout path within reach in a few hundred cycles. A read length of 40 exercises the 32-byte cap, and a zero-length program exercises the confirm-only path.

// File: rtl/nhs_pkg.sv
package nhs_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_ADDR, S_WDATA, S_CONF, S_PBUSY, S_RBUSY, S_RDATA, S_DONE
   } nhs_state_e;

   typedef enum logic [1:0] {
      P_WAIT, P_SETUP, P_STROBE, P_RECOV
   } nhs_phase_e;

   localparam logic [7:0] OP_READ    = 8'h00;
   localparam logic [7:0] OP_PROG    = 8'h80;
   localparam logic [7:0] OP_CONFIRM = 8'h10;
endpackage

// File: rtl/nhs_timer.sv
module nhs_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/nhs_pin_decode.sv
module nhs_pin_decode
   import nhs_pkg::*;
(
   input  nhs_state_e state,
   input  nhs_phase_e phase,
   input  logic       is_write,
   input  logic [7:0] addr_byte,
   input  logic [7:0] data_byte,
   output logic       cle,
   output logic       ale,
   output logic       ce_n,
   output logic       we_n,
   output logic       re_n,
   output logic [7:0] io_out,
   output logic       io_oe
);
   logic host_drive;

   always_comb begin
      host_drive = ((state == S_CMD) || (state == S_ADDR) || (state == S_WDATA) ||
                    (state == S_CONF)) && (phase != P_WAIT);
      cle   = host_drive && ((state == S_CMD) || (state == S_CONF));
      ale   = host_drive && (state == S_ADDR);
      we_n  = !(host_drive && (phase == P_STROBE));
      re_n  = !((state == S_RDATA) && (phase == P_STROBE));
      io_oe = host_drive;
      unique case (state)
         S_CMD:   io_out = is_write ? OP_PROG : OP_READ;
         S_ADDR:  io_out = addr_byte;
         S_WDATA: io_out = data_byte;
         S_CONF:  io_out = OP_CONFIRM;
         default: io_out = 8'h00;
      endcase
      unique case (state)
         S_CMD, S_ADDR, S_CONF, S_RBUSY: ce_n = 1'b0;
         S_WDATA: ce_n = (phase == P_WAIT);
         S_RDATA: ce_n = !((phase == P_STROBE) || (phase == P_RECOV));
         default: ce_n = 1'b1;
      endcase
   end
endmodule

// File: rtl/nand_host_seq.sv
module nand_host_seq
   import nhs_pkg::*;
#(
   parameter int PAGE_BYTES  = 32,
   parameter int ADDR_CYCLES = 3,
   parameter int LEN_W       = 8,
   parameter int TMR_W       = 8,
   parameter int T_WP        = 2,
   parameter int T_WH        = 2,
   parameter int T_CEA       = 4,
   parameter int T_REA       = 3,
   parameter int T_SETTLE    = 3,
   parameter int TIMEOUT     = 5000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_start,
   input  logic                     req_write,
   input  logic [8*ADDR_CYCLES-1:0] req_addr,
   input  logic [LEN_W-1:0]         req_len,
   input  logic [7:0]               wr_data,
   input  logic                     wr_valid,
   output logic                     wr_ready,
   output logic [7:0]               rd_data,
   output logic                     rd_valid,
   output logic                     req_ack,
   output logic                     req_err,
   output logic                     fl_cle,
   output logic                     fl_ale,
   output logic                     fl_ce_n,
   output logic                     fl_we_n,
   output logic                     fl_re_n,
   output logic [7:0]               fl_io_out,
   output logic                     fl_io_oe,
   input  logic [7:0]               fl_io_in,
   input  logic                     fl_rb
);
   localparam int ADDR_W = 8 * ADDR_CYCLES;
   localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
   localparam int AI_W   = (ADDR_CYCLES > 1) ? $clog2(ADDR_CYCLES) : 1;
   localparam int T_ACC  = (T_CEA > T_REA) ? T_CEA : T_REA;
   localparam int TO_W   = $clog2(TIMEOUT + 1);
   localparam logic [TMR_W-1:0] V_ZERO   = '0;
   localparam logic [TMR_W-1:0] V_WP     = TMR_W'(T_WP - 1);
   localparam logic [TMR_W-1:0] V_WH     = TMR_W'(T_WH - 1);
   localparam logic [TMR_W-1:0] V_ACC    = TMR_W'(T_ACC - 1);
   localparam logic [TMR_W-1:0] V_SETTLE = TMR_W'(T_SETTLE - 1);
   localparam logic [TO_W-1:0]  V_TO     = TO_W'(TIMEOUT - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CYCLES - 1);
   localparam logic [LEN_W-1:0] PAGE_L   = LEN_W'(PAGE_BYTES);

   initial begin
      assert_param_page: assert (PAGE_BYTES >= 1 && ADDR_CYCLES >= 1 && ADDR_CYCLES <= PAGE_BYTES)
         else $error("page and address cycle counts out of range");
      assert_param_len: assert (LEN_W >= CNT_W)
         else $error("LEN_W too narrow for PAGE_BYTES");
      assert_param_delay: assert (T_WP >= 1 && T_WH >= 1 && T_ACC >= 1 && T_SETTLE >= 1 && TIMEOUT >= 2)
         else $error("delays must be at least one cycle");
      assert_param_tmr: assert (T_WP < 2**TMR_W && T_WH < 2**TMR_W && T_ACC < 2**TMR_W && T_SETTLE < 2**TMR_W)
         else $error("TMR_W too narrow for delays");
   end

   nhs_state_e st_q, st_n;
   nhs_phase_e ph_q, ph_n;
   logic [CNT_W-1:0]  idx_q, idx_n, len_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q, err_q;
   logic [7:0]        dbuf_q;
   logic              t_ld, t_done, to_ld, to_done;
   logic [TMR_W-1:0]  t_val;
   logic              start, take, sample, set_err;
   logic [CNT_W-1:0]  len_eff;

   logic [7:0] addr_bytes [2**AI_W];
   for (genvar g = 0; g < 2**AI_W; g++) begin : g_abyte
      if (g < ADDR_CYCLES) begin : g_used
         assign addr_bytes[g] = addr_q[8*g +: 8];
      end else begin : g_pad
         assign addr_bytes[g] = 8'h00;
      end
   end

   assign len_eff = (req_len > PAGE_L) ? CNT_W'(PAGE_BYTES) : req_len[CNT_W-1:0];

   nhs_timer #(.W(TMR_W)) u_phase_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_ld), .load_val(t_val), .done(t_done));

   nhs_timer #(.W(TO_W)) u_poll_tmr (
      .clk(clk), .rst_n(rst_n), .load(to_ld), .load_val(V_TO), .done(to_done));

   always_comb begin
      st_n = st_q;  ph_n = ph_q;  idx_n = idx_q;
      t_ld = 1'b0;  t_val = V_ZERO; to_ld = 1'b0;
      start = 1'b0; take = 1'b0; sample = 1'b0; set_err = 1'b0;
      unique case (st_q)
         S_IDLE: if (req_start) begin
            start = 1'b1; st_n = S_CMD; ph_n = P_SETUP; t_ld = 1'b1;
         end
         S_CMD, S_ADDR, S_WDATA, S_CONF: begin
            unique case (ph_q)
               P_WAIT: if (wr_valid) begin
                  take = 1'b1; ph_n = P_SETUP; t_ld = 1'b1;
               end
               P_SETUP: if (t_done) begin
                  ph_n = P_STROBE; t_ld = 1'b1; t_val = V_WP;
               end
               P_STROBE: if (t_done) begin
                  ph_n = P_RECOV; t_ld = 1'b1; t_val = V_WH;
               end
               P_RECOV: if (t_done) begin
                  t_ld = 1'b1; ph_n = P_SETUP;
                  unique case (st_q)
                     S_CMD: begin st_n = S_ADDR; idx_n = '0; end
                     S_ADDR: begin
                        if (idx_q != ADDR_LAST) idx_n = idx_q + ONE;
                        else begin
                           idx_n = '0;
                           if (!wr_q) begin st_n = S_RBUSY; t_val = V_SETTLE; end
                           else if (len_q == '0) st_n = S_CONF;
                           else begin st_n = S_WDATA; ph_n = P_WAIT; end
                        end
                     end
                     S_WDATA: begin
                        idx_n = idx_q + ONE;
                        if (idx_q + ONE == len_q) st_n = S_CONF;
                        else ph_n = P_WAIT;
                     end
                     default: begin st_n = S_PBUSY; t_val = V_SETTLE; end
                  endcase
               end
            endcase
         end
         S_PBUSY, S_RBUSY: begin
            if (ph_q == P_SETUP) begin
               if (t_done) begin ph_n = P_STROBE; to_ld = 1'b1; end
            end else if (fl_rb) begin
               if (st_q == S_RBUSY && len_q != '0) begin
                  st_n = S_RDATA; ph_n = P_WAIT; idx_n = '0; t_ld = 1'b1; t_val = V_WH;
               end else st_n = S_DONE;
            end else if (to_done) begin
               set_err = 1'b1; st_n = S_DONE;
            end
         end
         S_RDATA: begin
            unique case (ph_q)
               P_STROBE: if (t_done) begin
                  sample = 1'b1; ph_n = P_RECOV; t_ld = 1'b1;
               end
               P_RECOV: if (t_done) begin
                  idx_n = idx_q + ONE;
                  if (idx_q + ONE == len_q) st_n = S_DONE;
                  else begin ph_n = P_WAIT; t_ld = 1'b1; t_val = V_WH; end
               end
               default: if (t_done) begin
                  ph_n = P_STROBE; t_ld = 1'b1; t_val = V_ACC;
               end
            endcase
         end
         default: begin st_n = S_IDLE; ph_n = P_WAIT; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= S_IDLE; ph_q <= P_WAIT; idx_q <= '0; len_q <= '0;
         addr_q <= '0; wr_q <= 1'b0; err_q <= 1'b0; dbuf_q <= 8'h00;
         rd_data <= 8'h00; rd_valid <= 1'b0;
      end else begin
         st_q <= st_n; ph_q <= ph_n; idx_q <= idx_n;
         rd_valid <= sample;
         if (sample) rd_data <= fl_io_in;
         if (take) dbuf_q <= wr_data;
         if (start) begin
            wr_q <= req_write; addr_q <= req_addr; len_q <= len_eff; err_q <= 1'b0;
         end
         if (set_err) err_q <= 1'b1;
      end
   end

   assign wr_ready = (st_q == S_WDATA) && (ph_q == P_WAIT);
   assign req_ack  = (st_q == S_DONE);
   assign req_err  = req_ack && err_q;

   nhs_pin_decode u_pins (
      .state(st_q), .phase(ph_q), .is_write(wr_q),
      .addr_byte(addr_bytes[idx_q[AI_W-1:0]]), .data_byte(dbuf_q),
      .cle(fl_cle), .ale(fl_ale), .ce_n(fl_ce_n), .we_n(fl_we_n), .re_n(fl_re_n),
      .io_out(fl_io_out), .io_oe(fl_io_oe));

   // Checker-only counter of write-strobe low cycles.
   logic [TMR_W:0] we_lo_q;
   always_ff @(posedge clk) begin
      if (!rst_n || fl_we_n) we_lo_q <= '0;
      else                   we_lo_q <= we_lo_q + (TMR_W+1)'(1);
   end

   assert_we_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (we_lo_q == (TMR_W+1)'(T_WP)));
   assert_bus_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_re_n |-> (!fl_io_oe && fl_we_n));
   assert_ce_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RBUSY) |-> !fl_ce_n);
   assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_cle && fl_ale));
   assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RDATA) |-> (idx_q < len_q && len_q <= CNT_W'(PAGE_BYTES)));
   assert_data_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |-> fl_ce_n);
endmodule

// File: tb/tb_nand_host_seq.sv
module tb_nand_host_seq;
   localparam int PAGE = 32, AC = 3, TWP = 2, TWH = 2, CEA = 4, REA = 3, TO = 200;
   localparam int BUSY_R = 20, BUSY_P = 25, LIMIT = 5000, NV = 6;
   // {write, addr[23:0], len[7:0], seed[7:0]}
   localparam logic [40:0] VEC [NV] = '{
      {1'b1, 24'h012345, 8'd32, 8'h11},
      {1'b0, 24'h012345, 8'd32, 8'h00},
      {1'b1, 24'h00A0B0, 8'd5,  8'h80},
      {1'b0, 24'h00A0B0, 8'd40, 8'h00},
      {1'b1, 24'h000003, 8'd0,  8'h00},
      {1'b0, 24'h7F0001, 8'd7,  8'h00}};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, req_start, req_write, wr_valid, wr_ready, rd_valid, req_ack, req_err;
   logic [23:0] req_addr;
   logic [7:0] req_len, wr_data, rd_data, fl_io_out, fl_io_in;
   logic fl_cle, fl_ale, fl_ce_n, fl_we_n, fl_re_n, fl_io_oe, fl_rb;

   nand_host_seq #(.PAGE_BYTES(PAGE), .ADDR_CYCLES(AC), .LEN_W(8), .TMR_W(8),
      .T_WP(TWP), .T_WH(TWH), .T_CEA(CEA), .T_REA(REA), .T_SETTLE(3), .TIMEOUT(TO)) dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .req_ack(req_ack),
      .req_err(req_err), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n),
      .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
      .fl_io_in(fl_io_in), .fl_rb(fl_rb));

   int checks = 0, errors = 0;
   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Program data stream: byte k of a request is seed + 3*k.
   logic [7:0] cur_seed = 8'h00;
   int wcnt = 0;
   always @(posedge clk) begin
      if (req_start) wcnt <= 0;
      else if (wr_valid && wr_ready) wcnt <= wcnt + 1;
   end
   assign wr_data = cur_seed + 8'(wcnt * 3);

   // Flash device model.
   logic [7:0] m_mem [PAGE];
   logic [7:0] m_buf [PAGE];
   logic [7:0] m_addr [AC];
   int m_mode, m_acnt, m_dcnt, m_busy, m_rptr, ce_cnt, re_cnt, we_lo;
   int m_ord, m_r5, m_r6, m_r11;
   bit m_rd_busy, ce_hi, stuck = 1'b0;
   logic prev_we, prev_re;

   assign fl_rb = (m_busy == 0) && !stuck;
   assign fl_io_in = (!fl_ce_n && !fl_re_n && ce_cnt >= CEA - 1 && re_cnt >= REA - 1)
                     ? m_mem[m_rptr[4:0]] : 8'hEE;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE; i++) m_mem[i] <= 8'hFF;
         m_mode <= 0; m_acnt <= 0; m_dcnt <= 0; m_busy <= 0; m_rptr <= 0;
         ce_cnt <= 0; re_cnt <= 0; we_lo <= 0; m_ord <= 0; m_r5 <= 0; m_r6 <= 0;
         m_r11 <= 0; m_rd_busy <= 1'b0; ce_hi <= 1'b0; prev_we <= 1'b1; prev_re <= 1'b1;
      end else begin
         prev_we <= fl_we_n; prev_re <= fl_re_n;
         ce_cnt <= fl_ce_n ? 0 : ce_cnt + 1;
         re_cnt <= fl_re_n ? 0 : re_cnt + 1;
         if (m_busy > 0) m_busy <= m_busy - 1;
         if (m_busy > 0 && m_rd_busy && fl_ce_n) m_r6 <= m_r6 + 1;
         if (fl_ce_n) ce_hi <= 1'b1;
         if (!fl_we_n) we_lo <= we_lo + 1;
         if (!prev_we && fl_we_n) begin
            we_lo <= 0;
            if (we_lo != TWP) m_r11 <= m_r11 + 1;
            if (fl_ce_n || !fl_io_oe) m_ord <= m_ord + 1;
            else if (fl_cle) begin
               if (fl_io_out == 8'h00) begin m_mode <= 1; m_acnt <= 0; end
               else if (fl_io_out == 8'h80) begin m_mode <= 2; m_acnt <= 0; m_dcnt <= 0; end
               else if (fl_io_out == 8'h10 && m_mode == 3) begin
                  for (int i = 0; i < PAGE; i++) if (i < m_dcnt) m_mem[i] <= m_buf[i];
                  m_busy <= BUSY_P; m_rd_busy <= 1'b0; m_mode <= 0;
               end else m_ord <= m_ord + 1;
            end else if (fl_ale) begin
               if ((m_mode == 1 || m_mode == 2) && m_acnt < AC) begin
                  m_addr[m_acnt] <= fl_io_out;
                  m_acnt <= m_acnt + 1;
                  if (m_acnt == AC - 1) begin
                     if (m_mode == 1) begin
                        m_busy <= BUSY_R; m_rd_busy <= 1'b1; m_rptr <= 0; m_mode <= 0;
                     end else m_mode <= 3;
                  end
               end else m_ord <= m_ord + 1;
            end else if (m_mode == 3 && m_dcnt < PAGE) begin
               m_buf[m_dcnt] <= fl_io_out;
               m_dcnt <= m_dcnt + 1;
               if (!ce_hi) m_r5 <= m_r5 + 1;
               ce_hi <= 1'b0;
            end else m_ord <= m_ord + 1;
         end
         if (!prev_re && fl_re_n) begin
            m_rptr <= m_rptr + 1;
            if (!ce_hi) m_r5 <= m_r5 + 1;
            ce_hi <= 1'b0;
         end
      end
   end

   // Monitors sampled away from the active edge.
   logic [7:0] rcv [64];
   int rcnt = 0, r8_viol = 0, r9_viol = 0;
   always @(negedge clk) begin
      if (req_start) rcnt = 0;
      if (rst_n) begin
         if (rd_valid && rcnt < 64) begin rcv[rcnt] = rd_data; rcnt++; end
         if ((fl_io_oe || !fl_we_n) && !fl_re_n) r8_viol++;
         if (req_ack && !req_err && !fl_rb) r9_viol++;
      end
   end

   logic [7:0] exp_mem [PAGE];
   bit got_ack, got_err;
   int cyc;

   task automatic run_op(input bit w, input logic [23:0] a, input logic [7:0] len,
                         input logic [7:0] seed);
      @(negedge clk);
      cur_seed = seed; req_write = w; req_addr = a; req_len = len;
      req_start = 1'b1; wr_valid = w;
      @(negedge clk);
      req_start = 1'b0;
      cyc = 1;
      while (!req_ack && cyc < LIMIT) begin @(negedge clk); cyc++; end
      got_ack = req_ack; got_err = req_err;
      if (!req_ack) check(1'b0, "watchdog", cyc, LIMIT);
      wr_valid = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
      wr_valid = 1'b0;
      for (int i = 0; i < PAGE; i++) exp_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(fl_ce_n && fl_we_n && fl_re_n, "R1 strobes high", {fl_ce_n, fl_we_n, fl_re_n}, 7);
      check(!fl_cle && !fl_ale && !fl_io_oe, "R1 latches/oe low", {fl_cle, fl_ale, fl_io_oe}, 0);
      check(!req_ack && !rd_valid && !wr_ready, "R1 user side idle", {req_ack, rd_valid, wr_ready}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         automatic bit w = VEC[v][40];
         automatic logic [23:0] a = VEC[v][39:16];
         automatic logic [7:0] len = VEC[v][15:8];
         automatic logic [7:0] sd = VEC[v][7:0];
         automatic int n = (int'(len) > PAGE) ? PAGE : int'(len);
         run_op(w, a, len, sd);
         check(got_ack && !got_err, "R9 normal completion", {got_ack, got_err}, 2);
         check({m_addr[2], m_addr[1], m_addr[0]} == a, "R2 R3 address bytes",
               int'({m_addr[2], m_addr[1], m_addr[0]}), int'(a));
         if (w) begin
            check(m_dcnt == n, "R3 R4 program byte count", m_dcnt, n);
            for (int i = 0; i < n; i++) exp_mem[i] = sd + 8'(3 * i);
         end else begin
            repeat (2) @(negedge clk);
            check(rcnt == n, "R4 read byte count", rcnt, n);
            for (int i = 0; i < n; i++)
               check(rcv[i] == exp_mem[i], "R7 read data", int'(rcv[i]), int'(exp_mem[i]));
         end
      end

      // R10: device stuck busy after confirm
      stuck = 1'b1;
      run_op(1'b1, 24'h000010, 8'd1, 8'h55);
      exp_mem[0] = 8'h55;
      check(got_ack && got_err, "R10 timeout error", {got_ack, got_err}, 3);
      check(cyc >= TO, "R10 timeout not early", cyc, TO);
      stuck = 1'b0;
      repeat (BUSY_P + 2) @(negedge clk);
      run_op(1'b0, 24'h000010, 8'd3, 8'h00);
      check(got_ack && !got_err, "R10 recovery after timeout", {got_ack, got_err}, 2);
      repeat (2) @(negedge clk);
      check(rcnt == 3, "R4 short read count", rcnt, 3);
      for (int i = 0; i < 3; i++)
         check(rcv[i] == exp_mem[i], "R7 read after recovery", int'(rcv[i]), int'(exp_mem[i]));

      check(m_ord == 0, "R2 R3 command/address/data order", m_ord, 0);
      check(m_r5 == 0, "R5 chip enable released between bytes", m_r5, 0);
      check(m_r6 == 0, "R6 chip enable held during read busy", m_r6, 0);
      check(r8_viol == 0, "R8 bus turnaround", r8_viol, 0);
      check(r9_viol == 0, "R9 ack only when ready", r9_viol, 0);
      check(m_r11 == 0, "R11 write strobe width", m_r11, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule